// File: doc/BRIEF.md
# Bus-Master Disk DMA Register Block

This block holds the software-visible control and status state of one bus-master disk DMA channel. A processor reaches it through a small register port: a write strobe, a 3-bit byte offset and a 32-bit write bus, with reads returned combinationally. The block holds three registers. The command register carries the start and transfer-direction controls. The status register carries the live active flag, the sticky error and interrupt flags, two scratch bits and one DMA-capable flag for each of the two drives. The third register is a 32-bit pointer to the descriptor table in memory.

The transfer engine receives start, direction and the table base from this block. It returns a busy level, a done pulse and an error pulse. An interrupt line follows the interrupt flag. Two combinational classifiers read the status byte. The end-of-transfer checker decides whether a finished transfer succeeded and, if not, gives an error code. The timeout checker picks the action to take when a watchdog expires: wait longer, fail, or reset the bus.

Top module: `bmdma_regs`

## Requirements
- R1: After a synchronous reset every register reads zero, and eng_start, eng_dir_to_mem, eng_table_base and irq are all 0.
- R2: A write to offset 0 stores wdata bit 0 as start, which drives eng_start, and wdata bit 3 as direction, which drives eng_dir_to_mem (1 means the device writes to memory). Offset 0 reads back start in bit 0 and direction in bit 3, with all other bits zero.
- R3: A write to offset 4 stores a 32-bit descriptor-table address whose two low bits are forced to zero. The stored value reads back at offset 4 and drives eng_table_base.
- R4: Status bit 0 (active) equals eng_busy as sampled at the previous clock edge. Writes to the status register do not change it.
- R5: An eng_done pulse sets status bit 2 (interrupt), and an eng_err pulse sets status bit 1 (error). If a set and a clearing write land in the same cycle, the set wins.
- R6: Writing offset 2 with bit 1 or bit 2 at 1 clears that flag. Writing 0 to either bit leaves the flag unchanged, so writing back a read value with both bits forced to 1 clears both flags.
- R7: Status bits 3 to 6 are plain read/write storage. Bits 5 and 6 mark drive 0 and drive 1 as DMA capable. Bit 7 reads zero.
- R8: irq equals status bit 2.
- R9: end_ok is 1 and end_code is 0 exactly when status bits {2,1,0} equal 3'b100. Otherwise end_ok is 0 and end_code equals the status byte ORed with 8'h10.
- R10: tmo_action (2'b00 reset, 2'b01 wait, 2'b10 error) is wait when status bits 3 and 4 are both 1. Otherwise it is error if bit 1 is set, else wait if bit 0 or bit 2 is set, else reset.
- R11: Writes to offsets 1, 3, 5, 6 and 7 change nothing, and reads at those offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| eng_busy | input | 1 | Engine busy level |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 1 | Engine error pulse |
| eng_start | output | 1 | Start/run control to engine |
| eng_dir_to_mem | output | 1 | Direction: 1 = device to memory |
| eng_table_base | output | 32 | Descriptor table base address |
| irq | output | 1 | Interrupt request |
| end_ok | output | 1 | End-of-transfer success |
| end_code | output | 8 | End-of-transfer error code, 0 on success |
| tmo_action | output | 2 | Timeout action code |

## Verification
Register writes, done and error pulses, and the busy level all take effect one clock edge after they are driven. Every output, including reg_rdata and both classifiers, is combinational from the registers, so each result is valid from that edge until the next one. The bench drives each stimulus on a falling edge and lets one rising edge pass. At the next falling edge it updates its model and compares every output, then steps reg_addr through all eight offsets inside that half cycle and compares each read.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;
    localparam int STAT_W = 8;
    localparam int PTR_LSB = 2;

    localparam logic [ADDR_W-1:0] OFS_CMD  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_STAT = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_TBL  = 3'd4;

    localparam int CMD_START_BIT = 0;
    localparam int CMD_DIR_BIT   = 3;
    localparam int ST_ACT  = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_INTR = 2;
    localparam int ST_SPL  = 3;
    localparam int ST_CAPL = 5;

    typedef enum logic [1:0] {
        TMO_RESET = 2'b00,
        TMO_WAIT  = 2'b01,
        TMO_ERROR = 2'b10
    } tmo_act_e;

    typedef struct packed {
        logic dir;
        logic start;
    } cmd_t;

    typedef struct packed {
        logic       zero7;
        logic [1:0] cap;
        logic [1:0] spare;
        logic       intr;
        logic       err;
        logic       act;
    } stat_t;

    function automatic logic end_good(input stat_t s);
        return {s.intr, s.err, s.act} == 3'b100;
    endfunction

    function automatic tmo_act_e tmo_pick(input stat_t s);
        if (s.spare == 2'b11) return TMO_WAIT;
        if (s.err)            return TMO_ERROR;
        if (s.act || s.intr)  return TMO_WAIT;
        return TMO_RESET;
    endfunction
endpackage

// File: rtl/bmdma_ctrl_reg.sv
module bmdma_ctrl_reg
    import bmdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_cmd,
    input  logic              wr_tbl,
    input  logic [DATA_W-1:0] wdata,
    output cmd_t              cmd_o,
    output logic [DATA_W-1:0] tbl_o
);
    localparam int PTR_W = DATA_W - PTR_LSB;

    cmd_t             cmd_q;
    logic [PTR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            ptr_q <= '0;
        end else begin
            if (wr_cmd) begin
                cmd_q.start <= wdata[CMD_START_BIT];
                cmd_q.dir   <= wdata[CMD_DIR_BIT];
            end
            if (wr_tbl) ptr_q <= wdata[DATA_W-1:PTR_LSB];
        end
    end

    assign cmd_o = cmd_q;
    assign tbl_o = {ptr_q, {PTR_LSB{1'b0}}};

    a_r2_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_cmd |=> $stable(cmd_o));
    a_r2_start_load: assert property (@(posedge clk) disable iff (rst)
        wr_cmd |=> cmd_o.start == $past(wdata[CMD_START_BIT]));
    a_r3_tbl_load: assert property (@(posedge clk) disable iff (rst)
        wr_tbl |=> tbl_o[DATA_W-1:PTR_LSB] == $past(wdata[DATA_W-1:PTR_LSB]));
endmodule

// File: rtl/bmdma_stat_reg.sv
module bmdma_stat_reg
    import bmdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stat,
    input  logic [STAT_W-1:0] wdata,
    input  logic              busy,
    input  logic              done,
    input  logic              err,
    output stat_t             stat_o
);
    stat_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.act <= busy;
            if (err)                       st_q.err <= 1'b1;
            else if (wr_stat && wdata[ST_ERR]) st_q.err <= 1'b0;
            if (done)                       st_q.intr <= 1'b1;
            else if (wr_stat && wdata[ST_INTR]) st_q.intr <= 1'b0;
            if (wr_stat) begin
                st_q.spare <= wdata[ST_SPL+1:ST_SPL];
                st_q.cap   <= wdata[ST_CAPL+1:ST_CAPL];
            end
        end
    end

    assign stat_o = st_q;

    a_r4_active_follows: assert property (@(posedge clk) disable iff (rst)
        busy |=> stat_o.act);
    a_r5_done_sets: assert property (@(posedge clk) disable iff (rst)
        done |=> stat_o.intr);
    a_r5_err_sets: assert property (@(posedge clk) disable iff (rst)
        err |=> stat_o.err);
    a_r6_w1c_intr: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && wdata[ST_INTR] && !done) |=> !stat_o.intr);
    a_r6_keep_err: assert property (@(posedge clk) disable iff (rst)
        (stat_o.err && !(wr_stat && wdata[ST_ERR])) |=> stat_o.err);
    a_r7_bit7_zero: assert property (@(posedge clk) disable iff (rst)
        !stat_o.zero7);
endmodule

// File: rtl/bmdma_classify.sv
module bmdma_classify
    import bmdma_pkg::*;
(
    input  stat_t             stat_i,
    output logic              end_ok,
    output logic [STAT_W-1:0] end_code,
    output tmo_act_e          tmo
);
    localparam logic [STAT_W-1:0] ERR_TAG = 8'h10;

    always_comb begin
        end_ok   = end_good(stat_i);
        end_code = end_ok ? '0 : (stat_i | ERR_TAG);
        tmo      = tmo_pick(stat_i);
    end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        eng_busy,
    input  logic        eng_done,
    input  logic        eng_err,
    output logic        eng_start,
    output logic        eng_dir_to_mem,
    output logic [31:0] eng_table_base,
    output logic        irq,
    output logic        end_ok,
    output logic [7:0]  end_code,
    output logic [1:0]  tmo_action
);
    cmd_t              cmd;
    stat_t             stat;
    logic [DATA_W-1:0] tbl;
    tmo_act_e          tmo;

    logic wr_cmd, wr_stat, wr_tbl;
    assign wr_cmd  = reg_wr && (reg_addr == OFS_CMD);
    assign wr_stat = reg_wr && (reg_addr == OFS_STAT);
    assign wr_tbl  = reg_wr && (reg_addr == OFS_TBL);

    bmdma_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .wr_tbl(wr_tbl),
        .wdata(reg_wdata), .cmd_o(cmd), .tbl_o(tbl)
    );

    bmdma_stat_reg u_stat (
        .clk(clk), .rst(rst), .wr_stat(wr_stat), .wdata(reg_wdata[STAT_W-1:0]),
        .busy(eng_busy), .done(eng_done), .err(eng_err), .stat_o(stat)
    );

    bmdma_classify u_cls (
        .stat_i(stat), .end_ok(end_ok), .end_code(end_code), .tmo(tmo)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CMD: begin
                reg_rdata[CMD_START_BIT] = cmd.start;
                reg_rdata[CMD_DIR_BIT]   = cmd.dir;
            end
            OFS_STAT: reg_rdata[STAT_W-1:0] = stat;
            OFS_TBL:  reg_rdata = tbl;
            default:  reg_rdata = '0;
        endcase
    end

    assign eng_start      = cmd.start;
    assign eng_dir_to_mem = cmd.dir;
    assign eng_table_base = tbl;
    assign irq            = stat.intr;
    assign tmo_action     = tmo;

    a_r8_irq_tracks_done: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> irq);
    a_r9_ok_code_zero: assert property (@(posedge clk) disable iff (rst)
        end_ok |-> (end_code == 8'h00 && irq));
    a_r9_fail_tagged: assert property (@(posedge clk) disable iff (rst)
        !end_ok |-> end_code[4]);
    a_r10_legal_code: assert property (@(posedge clk) disable iff (rst)
        tmo_action != 2'b11);
    a_r3_aligned: assert property (@(posedge clk) disable iff (rst)
        eng_table_base[1:0] == 2'b00);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!eng_start && !irq));
endmodule

// File: tb/bmdma_regs_tb_top.sv
`timescale 1ns/100ps
module bmdma_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_busy = 1'b0, eng_done = 1'b0, eng_err = 1'b0;
    logic        eng_start, eng_dir_to_mem, irq, end_ok;
    logic [31:0] eng_table_base;
    logic [7:0]  end_code;
    logic [1:0]  tmo_action;

    int n_chk = 0;
    int n_bad = 0;

    // bench model state
    logic       m_start, m_dir, m_act, m_err, m_intr;
    logic [1:0] m_spare, m_cap;
    logic [31:0] m_tbl;

    always #5 clk = ~clk;

    bmdma_regs dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
        .eng_done(eng_done), .eng_err(eng_err), .eng_start(eng_start),
        .eng_dir_to_mem(eng_dir_to_mem), .eng_table_base(eng_table_base),
        .irq(irq), .end_ok(end_ok), .end_code(end_code), .tmo_action(tmo_action)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] f_stat();
        return {1'b0, m_cap, m_spare, m_intr, m_err, m_act};
    endfunction

    function automatic logic [7:0] f_code(input logic [7:0] s);
        if (s[2:0] == 3'b100) return 8'h00;
        return s | 8'h10;
    endfunction

    function automatic logic [1:0] f_tmo(input logic [7:0] s);
        if (s[4:3] == 2'b11) return 2'b01;
        if (s[1]) return 2'b10;
        if (s[0] || s[2]) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [31:0] f_read(input int a);
        case (a)
            0: return {28'd0, m_dir, 2'b00, m_start};
            2: return {24'd0, f_stat()};
            4: return m_tbl;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check_all(input string why);
        logic [7:0] s;
        s = f_stat();
        chk(eng_start == m_start, {"R2 start ", why}, 32'(eng_start), 32'(m_start));
        chk(eng_dir_to_mem == m_dir, {"R2 dir ", why}, 32'(eng_dir_to_mem), 32'(m_dir));
        chk(eng_table_base == m_tbl, {"R3 base ", why}, eng_table_base, m_tbl);
        chk(irq == m_intr, {"R8 irq ", why}, 32'(irq), 32'(m_intr));
        chk(end_code == f_code(s), {"R9 code ", why}, 32'(end_code), 32'(f_code(s)));
        chk(end_ok == (s[2:0] == 3'b100), {"R9 ok ", why}, 32'(end_ok), 32'(s[2:0] == 3'b100));
        chk(tmo_action == f_tmo(s), {"R10 tmo ", why}, 32'(tmo_action), 32'(f_tmo(s)));
        for (int a = 0; a < 8; a++) begin
            reg_addr = 3'(a);
            #0.5;
            // R4 R5 R6 R7 R11 read-back of every offset
            chk(reg_rdata == f_read(a), $sformatf("R7/R11 read ofs %0d %s", a, why),
                reg_rdata, f_read(a));
        end
    endtask

    task automatic step(input logic wr, input logic [2:0] a, input logic [31:0] d,
                        input logic dn, input logic er, input logic by, input string why);
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        eng_done = dn; eng_err = er; eng_busy = by;
        @(posedge clk);
        m_act = by;
        if (er) m_err = 1'b1; else if (wr && a == 3'd2 && d[1]) m_err = 1'b0;
        if (dn) m_intr = 1'b1; else if (wr && a == 3'd2 && d[2]) m_intr = 1'b0;
        if (wr && a == 3'd2) begin m_spare = d[4:3]; m_cap = d[6:5]; end
        if (wr && a == 3'd0) begin m_start = d[0]; m_dir = d[3]; end
        if (wr && a == 3'd4) m_tbl = {d[31:2], 2'b00};
        @(negedge clk);
        reg_wr = 1'b0; eng_done = 1'b0; eng_err = 1'b0;
        check_all(why);
    endtask

    task automatic model_reset();
        m_start = 0; m_dir = 0; m_act = 0; m_err = 0; m_intr = 0;
        m_spare = 0; m_cap = 0; m_tbl = 0;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R1 reset state");

        // R2: start and direction
        step(1, 3'd0, 32'hFFFF_FFF9, 0, 0, 0, "R2 cmd set");
        step(1, 3'd0, 32'h0000_0008, 0, 0, 1, "R2 dir only, R4 busy");
        // R3: pointer with low bits forced
        step(1, 3'd4, 32'hDEAD_BEEF, 0, 0, 1, "R3 pointer");
        // R4: write cannot touch active
        step(1, 3'd2, 32'h0000_0001, 0, 0, 0, "R4 act write ignored");
        // R5/R9: done gives success code
        step(0, 3'd0, 0, 1, 0, 0, "R5 done sets intr R9 ok");
        // R5: set wins over same-cycle clear
        step(1, 3'd2, 32'h0000_0006, 1, 1, 0, "R5 set beats clear");
        // R6: zero writes keep flags
        step(1, 3'd2, 32'h0000_0060, 0, 0, 0, "R6 zeros keep R7 cap");
        // R6: write back with both clear bits
        step(1, 3'd2, {24'd0, f_stat() | 8'h06}, 0, 0, 0, "R6 writeback clears");
        // R10: spare bits both set -> wait
        step(1, 3'd2, 32'h0000_0018, 0, 1, 0, "R10 bits3/4 wait");
        step(1, 3'd2, 32'h0000_0002, 0, 0, 0, "R10 reset action");
        // R11: unmapped writes
        step(1, 3'd1, 32'hFFFF_FFFF, 0, 0, 0, "R11 ofs1");
        step(1, 3'd3, 32'hFFFF_FFFF, 0, 0, 0, "R11 ofs3");
        step(1, 3'd5, 32'hFFFF_FFFF, 0, 0, 0, "R11 ofs5");
        step(1, 3'd7, 32'hFFFF_FFFF, 0, 0, 0, "R11 ofs7");

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], r[4:2], $urandom, (r[7:5] == 0), (r[10:8] == 0),
                 r[11], "random");
        end

        // R1: reset mid-run
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_all("R1 re-reset");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule